// File: doc/BRIEF.md
# I2C Master Command-Queue Engine

This block is an I2C bus master that executes a queue of 11-bit command words. Each word holds an opcode in bits [10:8] and an operand byte in bits [7:0]. Software, or a host state machine, pushes words into a transmit command FIFO. The engine pops them one at a time and runs them on open-drain SCL and SDA lines. Bytes taken from the bus land in a receive FIFO, which the host drains through a read port.

A single receive command collects operand+1 bytes with no host involvement between bytes. Watermark comparisons on both FIFO levels produce the transmit-request and receive-ready flags, which can raise an interrupt. A separate timing block supplies the low and high SCL phase lengths, counted in clock cycles. Arbitration, target mode and the high-speed signalling variant are outside this block.

The opcodes are:
- 0: send a byte.
- 1: receive bytes into the FIFO.
- 2: STOP.
- 3: receive bytes and discard them.
- 4 and 6: START followed by an address byte.
- 5 and 7: START followed by an address byte, where a NACK on the address is tolerated.

Top module: `i2c_cmd_master`

## Requirements
- R1: Opcode 4 or 6 issues a START, or a repeated START when the bus is already held, and then sends operand[7:0] MSB first as the address byte. Opcode 0 sends its operand the same way. In both cases SDA changes only while SCL is low, except for START and STOP conditions.
- R2: Opcode 1 receives operand+1 bytes (1 to 256) into the receive FIFO. Every byte is ACKed, except the final byte of the command, which is NACKed when the next queued word is opcode 2.
- R3: Opcode 3 clocks in operand+1 bytes with the same ACK rule as R2 but pushes nothing into the receive FIFO.
- R4: Opcode 2 issues a STOP when the bus is held. A STOP seen on the lines sets the sticky stop flag until flag_clr[0]. bus_busy is set by a START seen on the lines and cleared by a STOP.
- R5: A NACK in the acknowledge slot of a checked byte (opcodes 0, 4, 6) sets the sticky NACK flag and triggers an automatic STOP. While the flag is set, no further command is popped; flag_clr[1] clears the flag.
- R6: Opcodes 5 and 7 behave like 4, but a NACK on their address byte sets no flag.
- R7: A push into a full command FIFO is dropped and sets the sticky overflow flag, which flag_clr[2] clears.
- R8: rx_word returns the head byte in bits [7:0], with bit 14 set when the receive FIFO is empty. A pop on an empty FIFO changes nothing.
- R9: tx_req is 1 when the command FIFO level is at or below tx_wm. rx_rdy is 1 when the receive FIFO level is above rx_wm. Both are registered.
- R10: irq is the OR of the enabled flags. irq_en bit 0 enables tx_req, bit 1 rx_rdy, bit 2 the stop flag and bit 3 the NACK flag.
- R11: mst_busy is 1 from the START until the STOP completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_push | input | 1 | Push cmd_word into the command FIFO |
| cmd_word | input | 11 | Opcode [10:8], operand [7:0] |
| tx_flush | input | 1 | Empty the command FIFO |
| rx_flush | input | 1 | Empty the receive FIFO |
| rx_pop | input | 1 | Pop the receive FIFO head |
| rx_word | output | 16 | Head byte [7:0], empty indication [14] |
| tx_level | output | 3 | Command FIFO level |
| rx_level | output | 3 | Receive FIFO level |
| tx_wm | input | 3 | Transmit watermark |
| rx_wm | input | 3 | Receive watermark |
| flag_clr | input | 3 | Clear stop [0], NACK [1], overflow [2] |
| irq_en | input | 4 | Interrupt enables |
| irq | output | 1 | Interrupt request |
| tx_req | output | 1 | Command FIFO at or below watermark |
| rx_rdy | output | 1 | Receive FIFO above watermark |
| stop_flag | output | 1 | Sticky stop detected |
| nack_flag | output | 1 | Sticky NACK detected |
| ovf_flag | output | 1 | Sticky command overflow |
| mst_busy | output | 1 | Engine owns the bus |
| bus_busy | output | 1 | Bus between START and STOP |
| t_lo | input | 8 | SCL low phase length in cycles, at least 2 |
| t_hi | input | 8 | SCL high phase length in cycles, at least 2 |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
FIFO levels move on the clock edge after a push or pop. The registered flags and irq follow one edge later. rx_word reflects the head in the same cycle. Bus results take one byte time, about 9·(t_lo+t_hi) cycles per byte plus a cycle of SDA lag. The stop and bus-busy flags trail the line event by two edges. The bench therefore waits for the stop flag, lets 20 more cycles pass, and only then samples outputs on the falling clock edge. For flag and level checks, it waits at least three edges after each push, pop, flush or clear pulse.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  typedef enum logic [3:0] {
    E_IDLE, E_RS_LO, E_RS_HI, E_ST_HI, E_B_LO, E_B_HI, E_SP_LO, E_SP_HI, E_SP_END
  } eng_st_t;

  localparam logic [2:0] OP_TX        = 3'd0;
  localparam logic [2:0] OP_RX        = 3'd1;
  localparam logic [2:0] OP_STOP      = 3'd2;
  localparam logic [2:0] OP_DISC      = 3'd3;
  localparam logic [2:0] OP_START     = 3'd4;
  localparam logic [2:0] OP_START_HI  = 3'd6;
  localparam int         RX_EMPTY_BIT = 14;
endpackage

// File: rtl/i2c_cmd_fifo.sv
module i2c_cmd_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> (count == $past(count))); // R7
  AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push && !flush) |=> (count == '0)); // R8
endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
  import i2c_cmd_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] t_lo,
  input  logic [TW-1:0] t_hi,
  input  logic          halt,
  input  logic          cmd_valid,
  input  logic [10:0]   cmd,
  output logic          cmd_pop,
  input  logic          rx_full,
  output logic          rx_push,
  output logic [7:0]    rx_byte,
  output logic          nack_set,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          busy
);
  eng_st_t       st, nxt;
  logic [TW-1:0] tmr;
  logic [7:0]    sh, cnt;
  logic [3:0]    bitn;
  logic          held, is_rx, keep, chk;
  logic          scl_q, sda_q, scl_c, sda_c;
  logic          tdone, stall, last_bit, ack_nack, drv;
  logic [2:0]    op;

  assign op       = cmd[10:8];
  assign tdone    = (tmr == '0);
  assign last_bit = (bitn == 4'd8);
  assign ack_nack = (cnt == 8'd0) && cmd_valid && (op == OP_STOP);
  assign stall    = (st == E_B_LO) && is_rx && keep && rx_full && (bitn == 4'd0);
  assign drv      = is_rx ? (last_bit && !ack_nack) : (!last_bit && !sh[7]);
  assign cmd_pop  = (st == E_IDLE) && cmd_valid && !halt;
  assign rx_push  = (st == E_B_HI) && tdone && last_bit && is_rx && keep;
  assign rx_byte  = sh;
  assign nack_set = (st == E_B_HI) && tdone && last_bit && !is_rx && chk && sda_i;
  assign scl_oe   = scl_q;
  assign sda_oe   = sda_q;
  assign busy     = held || (st != E_IDLE);

  always_comb begin
    nxt = st;
    unique case (st)
      E_IDLE: if (cmd_pop) begin
        if (op == OP_STOP)                                nxt = held ? E_SP_LO : E_IDLE;
        else if (op == OP_TX || op == OP_RX || op == OP_DISC) nxt = E_B_LO;
        else                                              nxt = held ? E_RS_LO : E_ST_HI;
      end
      E_RS_LO:  if (tdone) nxt = E_RS_HI;
      E_RS_HI:  if (tdone) nxt = E_ST_HI;
      E_ST_HI:  if (tdone) nxt = E_B_LO;
      E_B_LO:   if (tdone && !stall) nxt = E_B_HI;
      E_B_HI:   if (tdone) begin
        if (!last_bit)                      nxt = E_B_LO;
        else if (nack_set)                  nxt = E_SP_LO;
        else if (is_rx && cnt != 8'd0)      nxt = E_B_LO;
        else                                nxt = E_IDLE;
      end
      E_SP_LO:  if (tdone) nxt = E_SP_HI;
      E_SP_HI:  if (tdone) nxt = E_SP_END;
      E_SP_END: if (tdone) nxt = E_IDLE;
      default:  nxt = E_IDLE;
    endcase
  end

  always_comb begin
    scl_c = 1'b0;
    sda_c = 1'b0;
    unique case (st)
      E_IDLE:  scl_c = held;
      E_RS_LO: scl_c = 1'b1;
      E_ST_HI: sda_c = 1'b1;
      E_B_LO:  begin scl_c = 1'b1; sda_c = drv; end
      E_B_HI:  sda_c = sda_q;
      E_SP_LO: begin scl_c = 1'b1; sda_c = 1'b1; end
      E_SP_HI: sda_c = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= E_IDLE; tmr <= '0; sh <= '0; cnt <= '0; bitn <= '0;
      held <= 1'b0; is_rx <= 1'b0; keep <= 1'b0; chk <= 1'b0;
      scl_q <= 1'b0; sda_q <= 1'b0;
    end else begin
      st    <= nxt;
      scl_q <= scl_c;
      if (scl_q == scl_c) sda_q <= sda_c;
      if (nxt != st)
        tmr <= (nxt == E_RS_LO || nxt == E_B_LO || nxt == E_SP_LO) ? t_lo : t_hi;
      else if (!tdone && !stall)
        tmr <= tmr - 1'b1;
      if (cmd_pop) begin
        bitn  <= '0;
        sh    <= cmd[7:0];
        cnt   <= cmd[7:0];
        is_rx <= (op == OP_RX) || (op == OP_DISC);
        keep  <= (op == OP_RX);
        chk   <= (op == OP_TX) || (op == OP_START) || (op == OP_START_HI);
      end
      if (st == E_ST_HI) held <= 1'b1;
      if (st == E_SP_END && tdone) held <= 1'b0;
      if (st == E_B_HI && tdone) begin
        if (!last_bit) begin
          sh   <= {sh[6:0], sda_i};
          bitn <= bitn + 1'b1;
        end else begin
          bitn <= '0;
          if (is_rx && cnt != 8'd0) cnt <= cnt - 1'b1;
        end
      end
    end
  end

  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe && $past(!scl_oe) && !$stable(sda_oe)) |-> (st == E_ST_HI || st == E_SP_END)); // R1
  AST_NACK_STOPS: assert property (@(posedge clk) disable iff (rst)
    nack_set |=> (st == E_SP_LO)); // R5
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_cmd_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TW    = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_push,
  input  logic [10:0]   cmd_word,
  input  logic          tx_flush,
  input  logic          rx_flush,
  input  logic          rx_pop,
  output logic [15:0]   rx_word,
  output logic [CW-1:0] tx_level,
  output logic [CW-1:0] rx_level,
  input  logic [CW-1:0] tx_wm,
  input  logic [CW-1:0] rx_wm,
  input  logic [2:0]    flag_clr,
  input  logic [3:0]    irq_en,
  output logic          irq,
  output logic          tx_req,
  output logic          rx_rdy,
  output logic          stop_flag,
  output logic          nack_flag,
  output logic          ovf_flag,
  output logic          mst_busy,
  output logic          bus_busy,
  input  logic [TW-1:0] t_lo,
  input  logic [TW-1:0] t_hi,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe
);
  logic [10:0] cmd_head;
  logic [7:0]  rx_head, eng_byte;
  logic        tx_full, tx_empty, rx_full, rx_empty;
  logic        eng_pop, eng_push, eng_nack;
  logic        scl_d, sda_d, det_start, det_stop;

  i2c_cmd_fifo #(.W(11), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(tx_flush), .push(cmd_push), .din(cmd_word),
    .pop(eng_pop), .dout(cmd_head), .count(tx_level), .full(tx_full), .empty(tx_empty));

  i2c_cmd_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(rx_flush), .push(eng_push), .din(eng_byte),
    .pop(rx_pop), .dout(rx_head), .count(rx_level), .full(rx_full), .empty(rx_empty));

  i2c_cmd_engine #(.TW(TW)) u_eng (
    .clk(clk), .rst(rst), .t_lo(t_lo), .t_hi(t_hi), .halt(nack_flag),
    .cmd_valid(!tx_empty), .cmd(cmd_head), .cmd_pop(eng_pop),
    .rx_full(rx_full), .rx_push(eng_push), .rx_byte(eng_byte), .nack_set(eng_nack),
    .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(mst_busy));

  always_comb begin
    rx_word               = '0;
    rx_word[7:0]          = rx_head;
    rx_word[RX_EMPTY_BIT] = rx_empty;
  end

  assign det_start = scl_d && scl_i && sda_d && !sda_i;
  assign det_stop  = scl_d && scl_i && !sda_d && sda_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1; sda_d <= 1'b1;
      tx_req <= 1'b0; rx_rdy <= 1'b0; irq <= 1'b0;
      stop_flag <= 1'b0; nack_flag <= 1'b0; ovf_flag <= 1'b0; bus_busy <= 1'b0;
    end else begin
      scl_d  <= scl_i;
      sda_d  <= sda_i;
      tx_req <= (tx_level <= tx_wm);
      rx_rdy <= (rx_level > rx_wm);
      irq    <= |(irq_en & {nack_flag, stop_flag, rx_rdy, tx_req});
      if (det_stop)         stop_flag <= 1'b1;
      else if (flag_clr[0]) stop_flag <= 1'b0;
      if (eng_nack)         nack_flag <= 1'b1;
      else if (flag_clr[1]) nack_flag <= 1'b0;
      if (cmd_push && tx_full) ovf_flag <= 1'b1;
      else if (flag_clr[2])    ovf_flag <= 1'b0;
      if (det_start)        bus_busy <= 1'b1;
      else if (det_stop)    bus_busy <= 1'b0;
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !flag_clr[2]) |=> ovf_flag); // R7
endmodule

// File: tb/i2c_cmd_master_test.sv
module i2c_cmd_master_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_push = 1'b0;
  logic [10:0] cmd_word = '0;
  logic        tx_flush = 1'b0, rx_flush = 1'b0, rx_pop = 1'b0;
  logic [15:0] rx_word;
  logic [2:0]  tx_level, rx_level;
  logic [2:0]  tx_wm = 3'd1, rx_wm = 3'd0;
  logic [2:0]  flag_clr = '0;
  logic [3:0]  irq_en = '0;
  logic        irq, tx_req, rx_rdy, stop_flag, nack_flag, ovf_flag, mst_busy, bus_busy;
  logic [7:0]  t_lo = 8'd4, t_hi = 8'd4;
  logic        scl_oe, sda_oe, scl_w, sda_w;

  // bus target model state
  logic        s_act = 0, s_first = 0, s_rd = 0, s_low = 0, ack_en = 1;
  int          s_bit = 0;
  logic [7:0]  s_sh = '0, s_tx = '0, rd_val = 8'h5A;
  logic [7:0]  wr_log [32];
  logic        mack_log [32];
  int          wr_n = 0, mack_n = 0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  assign scl_w = ~scl_oe;
  assign sda_w = ~(sda_oe | s_low);

  always #2 clk = ~clk;

  i2c_cmd_master uut (
    .clk(clk), .rst(rst), .cmd_push(cmd_push), .cmd_word(cmd_word),
    .tx_flush(tx_flush), .rx_flush(rx_flush), .rx_pop(rx_pop), .rx_word(rx_word),
    .tx_level(tx_level), .rx_level(rx_level), .tx_wm(tx_wm), .rx_wm(rx_wm),
    .flag_clr(flag_clr), .irq_en(irq_en), .irq(irq), .tx_req(tx_req), .rx_rdy(rx_rdy),
    .stop_flag(stop_flag), .nack_flag(nack_flag), .ovf_flag(ovf_flag),
    .mst_busy(mst_busy), .bus_busy(bus_busy), .t_lo(t_lo), .t_hi(t_hi),
    .scl_i(scl_w), .sda_i(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe));

  always @(negedge sda_w) if (scl_w === 1'b1) begin
    s_act = 1; s_bit = 0; s_first = 1; s_low = 0;
  end
  always @(posedge sda_w) if (scl_w === 1'b1) begin
    s_act = 0; s_low = 0;
  end
  always @(posedge scl_w) if (s_act) begin
    if (s_bit < 8) s_sh = {s_sh[6:0], sda_w};
    else if (s_first) begin
      wr_log[wr_n] = s_sh; wr_n++; s_rd = s_sh[0]; s_first = 0;
    end else if (!s_rd) begin
      wr_log[wr_n] = s_sh; wr_n++;
    end else begin
      mack_log[mack_n] = sda_w; mack_n++;
      if (sda_w) s_act = 0;
    end
    s_bit = (s_bit == 8) ? 0 : s_bit + 1;
  end
  always @(negedge scl_w) if (s_act) begin
    if (s_first || !s_rd) s_low = (s_bit == 8) && ack_en;
    else begin
      if (s_bit == 0) begin s_tx = rd_val; rd_val = rd_val + 1; end
      s_low = (s_bit < 8) ? !s_tx[3'(7 - s_bit)] : 1'b0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [10:0] w);
    @(negedge clk); cmd_push = 1; cmd_word = w;
    @(negedge clk); cmd_push = 0;
  endtask

  task automatic clear(input logic [2:0] m);
    @(negedge clk); flag_clr = m;
    @(negedge clk); flag_clr = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_stop(input string req);
    int n = 0;
    while (!stop_flag && n < 20000) begin @(negedge clk); n++; end
    if (n >= 20000) chk(req, "stop timeout", 0, 1);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R9", "tx_req at reset", tx_req, 1);
    chk("R9", "rx_rdy at reset", rx_rdy, 0);
    chk("R8", "rx empty bit", rx_word[14], 1);
    chk("R11", "mst_busy at reset", mst_busy, 0);
    chk("R10", "irq masked", irq, 0);
    irq_en = 4'b0001;
    repeat (3) @(negedge clk);
    chk("R10", "irq from tx_req", irq, 1);
    irq_en = 4'b0100;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_write;
    int b = wr_n;
    push(11'h4A0); push(11'h03C); push(11'h081); push(11'h200);
    repeat (10) @(negedge clk);
    chk("R11", "mst_busy during xfer", mst_busy, 1);
    chk("R4", "bus_busy during xfer", bus_busy, 1);
    wait_stop("R4");
    chk("R1", "address byte", wr_log[b], 8'hA0);
    chk("R1", "data byte 0", wr_log[b+1], 8'h3C);
    chk("R1", "data byte 1", wr_log[b+2], 8'h81);
    chk("R5", "no nack on acked write", nack_flag, 0);
    chk("R4", "stop flag", stop_flag, 1);
    chk("R4", "bus_busy after stop", bus_busy, 0);
    chk("R11", "mst_busy after stop", mst_busy, 0);
    chk("R10", "irq from stop", irq, 1);
    clear(3'b001);
    chk("R4", "stop cleared", stop_flag, 0);
    chk("R10", "irq drops", irq, 0);
  endtask

  task automatic t_read;
    int b = wr_n;
    int m = mack_n;
    rd_val = 8'h5A;
    push(11'h4A0); push(11'h005); push(11'h4A1); push(11'h102); push(11'h200);
    wait_stop("R2");
    chk("R1", "write addr", wr_log[b], 8'hA0);
    chk("R1", "write data", wr_log[b+1], 8'h05);
    chk("R1", "repeated start addr", wr_log[b+2], 8'hA1);
    chk("R2", "ack byte 0", mack_log[m], 0);
    chk("R2", "ack byte 1", mack_log[m+1], 0);
    chk("R2", "nack last byte", mack_log[m+2], 1);
    chk("R2", "rx level", rx_level, 3);
    chk("R9", "rx_rdy above wm", rx_rdy, 1);
    chk("R7", "no overflow", ovf_flag, 0);
    for (int i = 0; i < 3; i++) begin
      chk("R2", "rx byte", rx_word[7:0], 8'h5A + i);
      chk("R8", "rx not empty", rx_word[14], 0);
      @(negedge clk); rx_pop = 1; @(negedge clk); rx_pop = 0;
    end
    chk("R8", "rx empty after drain", rx_word[14], 1);
    @(negedge clk); rx_pop = 1; @(negedge clk); rx_pop = 0;
    repeat (3) @(negedge clk);
    chk("R8", "empty pop ignored", rx_level, 0);
    chk("R9", "rx_rdy at wm", rx_rdy, 0);
    clear(3'b001);
  endtask

  task automatic t_discard;
    int m = mack_n;
    push(11'h4A1); push(11'h301); push(11'h200);
    wait_stop("R3");
    chk("R3", "discard keeps rx empty", rx_level, 0);
    chk("R3", "discard ack first", mack_log[m], 0);
    chk("R3", "discard nack last", mack_log[m+1], 1);
    clear(3'b001);
  endtask

  task automatic t_nack;
    ack_en = 0;
    push(11'h4A0); push(11'h011); push(11'h022);
    wait_stop("R5");
    chk("R5", "nack flag", nack_flag, 1);
    chk("R5", "halted level", tx_level, 2);
    chk("R5", "auto stop releases", mst_busy, 0);
    push(11'h033); push(11'h044); push(11'h055);
    repeat (3) @(negedge clk);
    chk("R7", "level capped", tx_level, 4);
    chk("R7", "overflow flag", ovf_flag, 1);
    chk("R9", "tx_req above wm", tx_req, 0);
    @(negedge clk); tx_flush = 1; @(negedge clk); tx_flush = 0;
    clear(3'b111);
    chk("R5", "nack cleared", nack_flag, 0);
    chk("R7", "overflow cleared", ovf_flag, 0);
    chk("R9", "tx_req after flush", tx_req, 1);
    chk("R5", "flushed", tx_level, 0);
    ack_en = 1;
  endtask

  task automatic t_start_nack;
    ack_en = 0;
    push(11'h5A0); push(11'h200);
    wait_stop("R6");
    chk("R6", "tolerated nack", nack_flag, 0);
    chk("R6", "queue consumed", tx_level, 0);
    clear(3'b001);
    ack_en = 1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_write();
    t_read();
    t_discard();
    t_nack();
    t_start_nack();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule